// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one 32-bit instruction word into the effective address that the instruction operates on. Bits are numbered the way the instruction format numbers them: bit 0 is the most significant bit, so format bit k is vector bit `31-k`. The unit takes the reference field from the word. If the word asks for it, the unit follows one level of indirection through a memory read port. It then applies post-indexing with a supplied index register value. Finally it reports the address, a flag that marks addresses naming one of the 16 fast registers of the current register block, and a flag that marks the wide unindexed form.

Instruction words that live in a trap or interrupt location are handled differently when their format bit 10 is clear. They then carry a 20-bit address that may be indirected but is never indexed. The unit accepts one instruction at a time. A word without indirection completes in a single cycle. An indirect word holds the unit busy until its memory response arrives. Page mapping, the register file and instruction execution happen elsewhere.

Top module: `eff_addr_gen`

## Requirements
- R1: With format bit 0 (vector bit 31) clear and the index field zero, the effective address equals format bits 15-31 (vector bits 16:0), zero-extended to 20 bits.
- R2: The index field is format bits 12-14 (vector bits 19:17). When it is nonzero in the short form, `idx_value` is added to the 17-bit address and the sum wraps modulo 2^17. `out_addr[19:17]` stays zero for every short-form result.
- R3: Format bit 0 set requests exactly one memory read at the reference address. Format bits 15-31 of the fetched word become the address. Bit 0 of the fetched word is ignored, and no second read is issued.
- R4: Indexing is applied to the address obtained after indirection, never to the reference address used for the read.
- R5: With `in_trap_loc` high and format bit 10 (vector bit 21) clear, the address is format bits 12-31 (vector bits 19:0). The index field is ignored and `out_long` is 1. With `in_trap_loc` low, or with bit 10 set, the short form applies and `out_long` is 0.
- R6: An indirect word in the wide form reads at the 20-bit reference address and takes its result from format bits 12-31 of the fetched word, unindexed.
- R7: `out_is_reg` is 1 exactly when the reported `out_addr` is below 16.
- R8: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`. A response is taken only after the request has been accepted; `mem_rsp_valid` while the request is pending has no effect.
- R9: `out_done` pulses for one cycle. It comes in the cycle after acceptance for a direct word, and in the cycle after `mem_rsp_valid` for an indirect word.
- R10: After reset `in_ready` is 1 and `out_done` and `mem_req_valid` are 0. `in_ready` is 0 from the acceptance of an indirect word until its result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_word | input | 32 | Instruction word, format bit 0 = vector bit 31 |
| in_trap_loc | input | 1 | Word was fetched from a trap or interrupt location |
| idx_value | input | 17 | Contents of the selected index register |
| mem_req_valid | output | 1 | Indirect read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Address of the indirect word |
| mem_rsp_valid | input | 1 | Indirect word returned |
| mem_rsp_data | input | 32 | Indirect word |
| out_done | output | 1 | Result valid for one cycle |
| out_addr | output | 20 | Effective address |
| out_is_reg | output | 1 | Address names a fast register (0-15) |
| out_long | output | 1 | Result is the wide unindexed form |

## Verification
A wrong latched context, such as the form flag, the index enable or the held index value, shows up only on the indirect path. It appears as a wrong `out_addr` or `out_long` in the single `out_done` cycle after the response, at most a few cycles after acceptance. A sequencer stuck in or skipping a state shows within one cycle, as `in_ready`, `mem_req_valid` or `out_done` out of step with the handshake. A second, spurious read shows as `mem_req_valid` in the cycle after the result. The bench therefore samples every handshake cycle, not only the final address.

// File: rtl/eag_pkg.sv
// Package: shared widths and sequencer state type for the effective address unit.
// Assumes the instruction format numbers bit 0 as the most significant bit.
package eag_pkg;
    localparam int WORD_W  = 32;   // instruction and memory word width
    localparam int SHORT_W = 17;   // normal reference address width
    localparam int LONG_W  = 20;   // wide trap/interrupt reference width
    localparam int REG_CNT = 16;   // fast registers addressed by low addresses

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } eag_state_t;
endpackage

// File: rtl/eag_decode.sv
// Module: eag_decode
// Splits an instruction word into indirect flag, form flag, index enable and
// reference address. Assumes format bit k sits at vector bit WORD_W-1-k.
module eag_decode #(
    parameter int WORD_W  = eag_pkg::WORD_W,
    parameter int SHORT_W = eag_pkg::SHORT_W,
    parameter int LONG_W  = eag_pkg::LONG_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              trap_loc,
    output logic              indirect,
    output logic              long_form,
    output logic              idx_en,
    output logic [LONG_W-1:0] ref_addr
);
    localparam int IND_BIT  = WORD_W - 1;    // format bit 0
    localparam int FORM_BIT = WORD_W - 11;   // format bit 10
    localparam int IDX_HI   = LONG_W - 1;    // format bit 12
    localparam int IDX_LO   = SHORT_W;       // format bit 14
    localparam int PAD_W    = LONG_W - SHORT_W;

    // Field extraction and form selection.
    always_comb begin
        indirect  = word[IND_BIT];
        long_form = trap_loc & ~word[FORM_BIT];
        idx_en    = ~long_form & (|word[IDX_HI:IDX_LO]);
        if (long_form)
            ref_addr = word[LONG_W-1:0];
        else
            ref_addr = {{PAD_W{1'b0}}, word[SHORT_W-1:0]};
    end
endmodule

// File: rtl/eag_sequencer.sv
// Module: eag_sequencer
// Accepts one instruction at a time and runs the single-level indirect read
// handshake. Produces a one-cycle resolve strobe with the base address and the
// context needed for post-indexing. Assumes the response arrives after the
// request has been accepted; responses at any other time are ignored.
module eag_sequencer #(
    parameter int WORD_W  = eag_pkg::WORD_W,
    parameter int SHORT_W = eag_pkg::SHORT_W,
    parameter int LONG_W  = eag_pkg::LONG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               dec_indirect,
    input  logic               dec_long,
    input  logic               dec_idx_en,
    input  logic [LONG_W-1:0]  dec_ref,
    input  logic [SHORT_W-1:0] idx_value,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LONG_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               res_go,
    output logic               res_long,
    output logic               res_idx_en,
    output logic [SHORT_W-1:0] res_idx_val,
    output logic [LONG_W-1:0]  res_base
);
    import eag_pkg::*;
    localparam int PAD_W = LONG_W - SHORT_W;

    eag_state_t         state_q;
    logic               ctx_long_q;
    logic               ctx_idx_en_q;
    logic [SHORT_W-1:0] ctx_idx_q;
    logic [LONG_W-1:0]  ctx_ref_q;
    logic               accept;
    logic               rsp_take;
    logic [LONG_W-1:0]  fetched;

    // Handshake qualifiers.
    always_comb begin
        in_ready      = (state_q == ST_IDLE);
        accept        = in_valid & in_ready;
        rsp_take      = (state_q == ST_WAIT) & mem_rsp_valid;
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = ctx_ref_q;
    end

    // Address field of the fetched word; its own indirect bit is never looked at.
    always_comb begin
        if (ctx_long_q)
            fetched = mem_rsp_data[LONG_W-1:0];
        else
            fetched = {{PAD_W{1'b0}}, mem_rsp_data[SHORT_W-1:0]};
    end

    // Resolve strobe and operand selection: live word when direct, context when indirect.
    always_comb begin
        res_go = (accept & ~dec_indirect) | rsp_take;
        if (state_q == ST_WAIT) begin
            res_long    = ctx_long_q;
            res_idx_en  = ctx_idx_en_q;
            res_idx_val = ctx_idx_q;
            res_base    = fetched;
        end else begin
            res_long    = dec_long;
            res_idx_en  = dec_idx_en;
            res_idx_val = idx_value;
            res_base    = dec_ref;
        end
    end

    // State register: idle -> request -> wait response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept && dec_indirect) state_q <= ST_REQ;
                ST_REQ:  if (mem_req_ready)          state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid)          state_q <= ST_IDLE;
                default:                             state_q <= ST_IDLE;
            endcase
        end
    end

    // Context capture at acceptance, held for the indirect path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_long_q   <= 1'b0;
            ctx_idx_en_q <= 1'b0;
            ctx_idx_q    <= '0;
            ctx_ref_q    <= '0;
        end else if (accept) begin
            ctx_long_q   <= dec_long;
            ctx_idx_en_q <= dec_idx_en;
            ctx_idx_q    <= idx_value;
            ctx_ref_q    <= dec_ref;
        end
    end
endmodule

// File: rtl/eag_resolve.sv
// Module: eag_resolve
// Combinational post-indexing and fast-register detection. Assumes base has
// zero upper bits in the short form; the short sum wraps at SHORT_W bits.
module eag_resolve #(
    parameter int SHORT_W = eag_pkg::SHORT_W,
    parameter int LONG_W  = eag_pkg::LONG_W,
    parameter int REG_CNT = eag_pkg::REG_CNT
) (
    input  logic               long_form,
    input  logic               idx_en,
    input  logic [SHORT_W-1:0] idx_val,
    input  logic [LONG_W-1:0]  base,
    output logic [LONG_W-1:0]  addr,
    output logic               is_reg
);
    localparam int PAD_W = LONG_W - SHORT_W;

    logic [SHORT_W-1:0] sum;

    // Post-index add, then form select and register-range test.
    always_comb begin
        sum = base[SHORT_W-1:0] + (idx_en ? idx_val : '0);
        if (long_form)
            addr = base;
        else
            addr = {{PAD_W{1'b0}}, sum};
        is_reg = (addr < LONG_W'(REG_CNT));
    end
endmodule

// File: rtl/eff_addr_gen.sv
// Module: eff_addr_gen (top)
// Effective address generation: decode, single-level indirection, post-index,
// registered result with a one-cycle done pulse. Assumes one instruction in
// flight; in_ready low while an indirect read is outstanding.
module eff_addr_gen #(
    parameter int WORD_W  = eag_pkg::WORD_W,
    parameter int SHORT_W = eag_pkg::SHORT_W,
    parameter int LONG_W  = eag_pkg::LONG_W,
    parameter int REG_CNT = eag_pkg::REG_CNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_trap_loc,
    input  logic [SHORT_W-1:0] idx_value,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LONG_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               out_done,
    output logic [LONG_W-1:0]  out_addr,
    output logic               out_is_reg,
    output logic               out_long
);
    logic               dec_indirect;
    logic               dec_long;
    logic               dec_idx_en;
    logic [LONG_W-1:0]  dec_ref;
    logic               res_go;
    logic               res_long;
    logic               res_idx_en;
    logic [SHORT_W-1:0] res_idx_val;
    logic [LONG_W-1:0]  res_base;
    logic [LONG_W-1:0]  res_addr;
    logic               res_is_reg;

    eag_decode #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_decode (
        .word      (in_word),
        .trap_loc  (in_trap_loc),
        .indirect  (dec_indirect),
        .long_form (dec_long),
        .idx_en    (dec_idx_en),
        .ref_addr  (dec_ref)
    );

    eag_sequencer #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .dec_indirect  (dec_indirect),
        .dec_long      (dec_long),
        .dec_idx_en    (dec_idx_en),
        .dec_ref       (dec_ref),
        .idx_value     (idx_value),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_go        (res_go),
        .res_long      (res_long),
        .res_idx_en    (res_idx_en),
        .res_idx_val   (res_idx_val),
        .res_base      (res_base)
    );

    eag_resolve #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .REG_CNT(REG_CNT)) u_resolve (
        .long_form (res_long),
        .idx_en    (res_idx_en),
        .idx_val   (res_idx_val),
        .base      (res_base),
        .addr      (res_addr),
        .is_reg    (res_is_reg)
    );

    // Result register: capture on resolve, done pulses for that one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done   <= 1'b0;
            out_addr   <= '0;
            out_is_reg <= 1'b0;
            out_long   <= 1'b0;
        end else begin
            out_done <= res_go;
            if (res_go) begin
                out_addr   <= res_addr;
                out_is_reg <= res_is_reg;
                out_long   <= res_long;
            end
        end
    end
endmodule

// File: rtl/eff_addr_gen_checker.sv
// Module: eff_addr_gen_checker
// Port-level properties of the effective address unit, bound to the top.
module eff_addr_gen_checker #(
    parameter int WORD_W  = eag_pkg::WORD_W,
    parameter int SHORT_W = eag_pkg::SHORT_W,
    parameter int LONG_W  = eag_pkg::LONG_W,
    parameter int REG_CNT = eag_pkg::REG_CNT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_word,
    input logic              in_trap_loc,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [LONG_W-1:0] mem_req_addr,
    input logic              out_done,
    input logic [LONG_W-1:0] out_addr,
    input logic              out_is_reg,
    input logic              out_long
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !in_ready); // R10
    AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_word[WORD_W-1] |=> out_done); // R9
    AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_done && !out_long |-> out_addr[LONG_W-1:SHORT_W] == '0); // R2
    AST_REG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_is_reg == (out_addr < LONG_W'(REG_CNT))); // R7
    AST_NO_TRAP_NO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_word[WORD_W-1] && !in_trap_loc |=> !out_long); // R5
endmodule

bind eff_addr_gen eff_addr_gen_checker #(
    .WORD_W(WORD_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .REG_CNT(REG_CNT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_word       (in_word),
    .in_trap_loc   (in_trap_loc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .out_done      (out_done),
    .out_addr      (out_addr),
    .out_is_reg    (out_is_reg),
    .out_long      (out_long)
);

// File: tb/eff_addr_gen_bench.sv
// Bench: directed corners plus seeded random words, checked against a model.
module eff_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        in_trap_loc = 1'b0;
    logic [16:0] idx_value = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [19:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        out_done;
    logic [19:0] out_addr;
    logic        out_is_reg;
    logic        out_long;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    eff_addr_gen u_eff_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_trap_loc(in_trap_loc), .idx_value(idx_value),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .out_done(out_done), .out_addr(out_addr),
        .out_is_reg(out_is_reg), .out_long(out_long)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_fn(input logic [19:0] a);
        return ({12'h0, a} * 32'h9E3779B1) ^ {a[7:0], 24'h5A5A5A};
    endfunction

    // Returns {long, addr[19:0]} from the requirements.
    function automatic logic [20:0] model(input logic [31:0] w, input logic tr,
                                          input logic [16:0] ix, input logic [31:0] md);
        logic        lf;
        logic [16:0] s;
        lf = tr && !w[21];
        if (lf) return {1'b1, (w[31] ? md[19:0] : w[19:0])};
        s = w[31] ? md[16:0] : w[16:0];
        if (w[19:17] != 3'd0) s = s + ix;
        return {1'b0, 3'b000, s};
    endfunction

    task automatic run_vec(input logic [31:0] w, input logic tr, input logic [16:0] ix,
                           input bit frc, input logic [31:0] fv, input bit junk);
        logic [20:0] exp;
        logic [31:0] md;
        logic        lf;
        logic [19:0] raddr;
        int          n;
        lf    = tr && !w[21];
        raddr = lf ? w[19:0] : {3'b000, w[16:0]};
        md    = frc ? fv : mem_fn(raddr);
        exp   = model(w, tr, ix, md);
        @(negedge clk);
        check("R10 ready before accept", {31'b0, in_ready}, 32'd1);
        in_valid = 1'b1; in_word = w; in_trap_loc = tr; idx_value = ix;
        @(negedge clk);
        in_valid = 1'b0; in_word = $urandom; in_trap_loc = 1'($urandom); idx_value = 17'($urandom);
        if (w[31]) begin
            check("R10 busy", {31'b0, in_ready}, 32'd0);
            check("R3 request", {31'b0, mem_req_valid}, 32'd1);
            check("R3 R6 request address", {12'b0, mem_req_addr}, {12'b0, raddr});
            n = $urandom_range(0, 2);
            if (junk && n == 0) n = 1;
            for (int i = 0; i < n; i++) begin
                if (junk && i == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = ~md; end
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                check("R8 hold valid", {31'b0, mem_req_valid}, 32'd1);
                check("R8 hold address", {12'b0, mem_req_addr}, {12'b0, raddr});
                check("R8 early response ignored", {31'b0, out_done}, 32'd0);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            check("R8 request dropped", {31'b0, mem_req_valid}, 32'd0);
            check("R9 no early done", {31'b0, out_done}, 32'd0);
            n = $urandom_range(0, 2);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                check("R9 wait no done", {31'b0, out_done}, 32'd0);
                check("R10 busy wait", {31'b0, in_ready}, 32'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = md;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        end
        check("R9 done", {31'b0, out_done}, 32'd1);
        check("R1 R2 R4 R5 R6 address", {12'b0, out_addr}, {12'b0, exp[19:0]});
        check("R5 long flag", {31'b0, out_long}, {31'b0, exp[20]});
        check("R7 register flag", {31'b0, out_is_reg}, {31'b0, (exp[19:0] < 20'd16)});
        @(negedge clk);
        check("R9 single pulse", {31'b0, out_done}, 32'd0);
        check("R3 single level", {31'b0, mem_req_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset ready", {31'b0, in_ready}, 32'd1);
        check("R10 reset done", {31'b0, out_done}, 32'd0);
        check("R10 reset request", {31'b0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        // R1 / R7: direct, low register address and first memory address
        run_vec(32'h0000_0005, 1'b0, 17'h1234, 1'b0, '0, 1'b0);
        run_vec(32'h0000_0010, 1'b0, 17'h0000, 1'b0, '0, 1'b0);
        run_vec(32'h7FC0_000F, 1'b0, 17'h0001, 1'b0, '0, 1'b0);
        // R2: wrap modulo 2^17, index field 3
        run_vec(32'h0007_FFF0, 1'b0, 17'h00020, 1'b0, '0, 1'b0);
        // R3: fetched word has its own indirect bit set, ignored
        run_vec(32'h8000_0100, 1'b0, 17'h0, 1'b1, 32'h8001_2345, 1'b0);
        // R4: indirect then index (field 1)
        run_vec(32'h8002_0200, 1'b0, 17'h00003, 1'b1, 32'h0000_0400, 1'b0);
        // R5: wide trap form, index field nonzero but not applied
        run_vec(32'h000F_FFFF, 1'b1, 17'h00005, 1'b0, '0, 1'b0);
        // R5: trap location with bit 10 set uses the short form
        run_vec(32'h002E_0008, 1'b1, 17'h00002, 1'b0, '0, 1'b0);
        // R6: wide indirect
        run_vec(32'h800A_BCDE, 1'b1, 17'h00007, 1'b1, 32'h000F_0003, 1'b0);
        // R8: response offered while request still pending
        run_vec(32'h8000_0777, 1'b0, 17'h0, 1'b0, '0, 1'b1);
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(0, 3) == 0) w[16:0] = 17'($urandom_range(0, 31));
            run_vec(w, 1'($urandom), 17'($urandom), 1'b0, '0, ($urandom_range(0, 7) == 0));
        end
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule